// File: doc/BRIEF.md
# Single-Wire Debug Bit Transmitter

This block is the target side of one bit slot on a shared open-drain debug wire. The host opens every bit slot by pulling the wire low. The block brings the wire level into its own clock domain and checks that the low is real. It then completes the slot. For a logic zero it holds the wire low for a fixed number of cycles. For a logic one it leaves the wire floating. In both cases it closes the slot with a one-cycle active-high speed-up pulse, which sharpens the rising edge.

Upstream logic offers the next bit through a valid/ready handshake into a single holding register. The register can be refilled while a slot is still running. If a slot starts while the register is empty, the block sends a logic one and flags an underrun for that slot. The two drive-enable outputs go to an open-drain pad, which also supplies the wire level on `pin_in`.

The controller has five states: `ST_IDLE`, `ST_HOLD_LOW`, `ST_FLOAT`, `ST_SPEEDUP` and `ST_RECOVER`. Its transitions are:
- IDLE→HOLD_LOW on a qualified start with a zero to send.
- IDLE→FLOAT on a qualified start with a one to send, or with no bit loaded.
- HOLD_LOW→SPEEDUP after the low count.
- FLOAT→SPEEDUP after the pulse delay.
- SPEEDUP→RECOVER always.
- RECOVER→IDLE always.

Top module: `wire_bit_tx`

## Requirements
- R1: After reset, `drive_low`, `drive_high`, `busy` and `underrun` are 0 and `tx_ready` is 1.
- R2: `pin_in` passes through two flops. A slot starts only when the synchronized line is low for two consecutive cycles after being seen high while idle. If the first clock edge that samples `pin_in` low is edge k, then `busy` rises after edge k+3, which is the perceived start. A low lasting one cycle starts nothing.
- R3: For a zero, `drive_low` is 1 for exactly 13 cycles, from after edge k+3 through after edge k+15.
- R4: For a one, or for a slot with no bit loaded, `drive_low` stays 0 for the whole slot.
- R5: The speed-up pulse has `drive_high` equal to 1 for exactly one cycle, and it never overlaps `drive_low`. For a one, the pulse comes 7 cycles after the perceived start (after edge k+10). For a zero, it comes in the cycle right after the low period ends (after edge k+16).
- R6: `busy` drops one cycle after the speed-up pulse. The block's own low drive never starts a new slot.
- R7: A bit is accepted when `tx_valid` and `tx_ready` are both 1, where `tx_bit` equal to 1 means logic one. `tx_ready` is 0 while a bit is held. The held bit is consumed at the perceived start of a slot. A new bit may be loaded during a slot, and it is used in the next slot.
- R8: If no bit is held at the start, the slot sends a logic one and `underrun` is 1 for exactly the cycles in which `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Level of the shared wire, from the pad |
| tx_valid | input | 1 | Next bit is offered |
| tx_bit | input | 1 | Value of the offered bit |
| tx_ready | output | 1 | Holding register is empty |
| drive_low | output | 1 | Enable for the pad's pull-down |
| drive_high | output | 1 | Enable for the speed-up pull-up |
| busy | output | 1 | A bit slot is in progress |
| underrun | output | 1 | The current slot started with no bit loaded |

## Verification
Every slot result is due a fixed number of clock edges after the first edge that samples the host's low; that first edge is edge k:
- `busy` and `drive_low` appear three edges later.
- For a one, the pulse appears ten edges later.
- For a zero, the pulse appears sixteen edges later.
- `busy` clears two edges after the pulse.

The bench drives and samples on falling edges. In each slot it numbers every sample by the edges since k, and it compares all outputs against expected functions of that number at every sample, so both early and late transitions are caught. A bit loaded during a slot is expected to lower `tx_ready` one edge after it is accepted.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD_LOW,
        ST_FLOAT,
        ST_SPEEDUP,
        ST_RECOVER
    } wbt_state_e;
endpackage

// File: rtl/wbt_sync.sv
module wbt_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wbt_edge.sv
module wbt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_s,
    output logic start
);
    logic line_d;
    logic armed;

    assign start = enable & armed & ~line_s & ~line_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_d <= 1'b1;
            armed  <= 1'b0;
        end else begin
            line_d <= line_s;
            if (!enable) begin
                armed <= 1'b0;
            end else if (line_s) begin
                armed <= 1'b1;
            end else if (start) begin
                armed <= 1'b0;
            end
        end
    end

    // R2
    start_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !line_s && !$past(line_s));
endmodule

// File: rtl/wbt_holding.sv
module wbt_holding (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_bit,
    input  logic consume,
    output logic tx_ready,
    output logic avail,
    output logic bit_out
);
    logic have;
    logic held;
    logic accept;

    assign accept   = tx_valid & ~have;
    assign tx_ready = ~have;
    assign avail    = have;
    assign bit_out  = have ? held : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have <= 1'b0;
            held <= 1'b1;
        end else if (accept) begin
            have <= 1'b1;
            held <= tx_bit;
        end else if (consume) begin
            have <= 1'b0;
        end
    end

    // R7
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready);
    // R7
    consume_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !tx_ready |=> tx_ready);
endmodule

// File: rtl/wbt_fsm.sv
module wbt_fsm
    import wbt_pkg::*;
#(
    parameter int ZERO_LOW_CYCLES = 13,
    parameter int ONE_PULSE_DELAY = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic send_bit,
    input  logic bit_avail,
    output logic drive_low,
    output logic drive_high,
    output logic busy,
    output logic underrun,
    output logic idle
);
    localparam int MAX_COUNT = (ZERO_LOW_CYCLES > ONE_PULSE_DELAY) ? ZERO_LOW_CYCLES : ONE_PULSE_DELAY;
    localparam int CW        = $clog2(MAX_COUNT + 1);
    localparam logic [CW-1:0] ZERO_LAST = CW'(ZERO_LOW_CYCLES - 1);
    localparam logic [CW-1:0] ONE_LAST  = CW'(ONE_PULSE_DELAY - 1);

    wbt_state_e    state;
    logic [CW-1:0] cnt;
    logic          und_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            und_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        und_q <= ~bit_avail;
                        state <= send_bit ? ST_FLOAT : ST_HOLD_LOW;
                    end
                end
                ST_HOLD_LOW: begin
                    if (cnt == ZERO_LAST) begin
                        state <= ST_SPEEDUP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FLOAT: begin
                    if (cnt == ONE_LAST) begin
                        state <= ST_SPEEDUP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SPEEDUP: begin
                    state <= ST_RECOVER;
                end
                ST_RECOVER: begin
                    und_q <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        drive_low  = 1'b0;
        drive_high = 1'b0;
        busy       = 1'b1;
        idle       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                idle = 1'b1;
            end
            ST_HOLD_LOW: drive_low  = 1'b1;
            ST_FLOAT:    drive_low  = 1'b0;
            ST_SPEEDUP:  drive_high = 1'b1;
            ST_RECOVER:  drive_high = 1'b0;
            default: begin
                busy = 1'b0;
                idle = 1'b1;
            end
        endcase
    end

    assign underrun = und_q;

    logic [CW:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else begin
            low_run <= drive_low ? low_run + 1'b1 : '0;
        end
    end

    // R2
    start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R6
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    // R3
    low_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> low_run < (CW+1)'(ZERO_LOW_CYCLES));
    // R3
    low_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) |-> low_run == (CW+1)'(ZERO_LOW_CYCLES));
    // R5
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_low && drive_high));
    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_high |=> !drive_high);
    // R5
    pulse_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) |-> drive_high);
    // R6
    pulse_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_high |=> busy);
    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(drive_high, 2));
    // R8
    underrun_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> busy);
endmodule

// File: rtl/wire_bit_tx.sv
module wire_bit_tx #(
    parameter int SYNC_STAGES     = 2,
    parameter int ZERO_LOW_CYCLES = 13,
    parameter int ONE_PULSE_DELAY = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic tx_ready,
    output logic drive_low,
    output logic drive_high,
    output logic busy,
    output logic underrun
);
    logic line_s;
    logic start;
    logic idle;
    logic avail;
    logic send_bit;

    wbt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (line_s)
    );

    wbt_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (idle),
        .line_s (line_s),
        .start  (start)
    );

    wbt_holding u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_bit   (tx_bit),
        .consume  (start),
        .tx_ready (tx_ready),
        .avail    (avail),
        .bit_out  (send_bit)
    );

    wbt_fsm #(
        .ZERO_LOW_CYCLES (ZERO_LOW_CYCLES),
        .ONE_PULSE_DELAY (ONE_PULSE_DELAY)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .send_bit   (send_bit),
        .bit_avail  (avail),
        .drive_low  (drive_low),
        .drive_high (drive_high),
        .busy       (busy),
        .underrun   (underrun),
        .idle       (idle)
    );
endmodule

// File: tb/test_wire_bit_tx.sv
module test_wire_bit_tx;
    localparam int LAT  = 3;
    localparam int ZL   = 13;
    localparam int PD   = 7;
    localparam int SPAN = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic tx_valid = 1'b0;
    logic tx_bit = 1'b0;
    logic tx_ready, drive_low, drive_high, busy, underrun;
    logic pin_in;

    int checks = 0;
    int failures = 0;
    bit model_have = 1'b0;
    bit model_bit = 1'b1;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign pin_in = ~(host_low | drive_low);

    wire_bit_tx i_wire_bit_tx (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tx_valid(tx_valid), .tx_bit(tx_bit),
        .tx_ready(tx_ready), .drive_low(drive_low), .drive_high(drive_high),
        .busy(busy), .underrun(underrun)
    );

    function automatic bit exp_low(bit b, int m);
        return (b == 1'b0) && (m >= LAT) && (m < LAT + ZL);
    endfunction
    function automatic bit exp_high(bit b, int m);
        return b ? (m == LAT + PD) : (m == LAT + ZL);
    endfunction
    function automatic bit exp_busy(bit b, int m);
        return (m >= LAT) && (m <= (b ? LAT + PD + 1 : LAT + ZL + 1));
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic load(bit b);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_bit = b;
        @(negedge clk);
        tx_valid = 1'b0;
        model_have = 1'b1;
        model_bit = b;
    endtask

    task automatic run_slot(int hold, bit mid, bit mid_b);
        bit b, und, had;
        had = model_have;
        b = model_have ? model_bit : 1'b1;
        und = !model_have;
        model_have = 1'b0;
        @(negedge clk);
        host_low = 1'b1;
        for (int j = 1; j <= SPAN; j++) begin
            int m;
            bit rdy;
            @(negedge clk);
            m = j - 1;
            if (j == hold) host_low = 1'b0;
            check(b ? "R4 drive_low" : "R3 drive_low", drive_low, exp_low(b, m));
            check("R5 drive_high", drive_high, exp_high(b, m));
            check("R2/R6 busy", busy, exp_busy(b, m));
            check("R8 underrun", underrun, und && exp_busy(b, m));
            rdy = (j <= LAT) ? !had : !(mid && j >= 7);
            check("R7 tx_ready", tx_ready, rdy);
            if (mid && j == 6) begin tx_valid = 1'b1; tx_bit = mid_b; end
            if (mid && j == 7) begin
                tx_valid = 1'b0;
                model_have = 1'b1;
                model_bit = mid_b;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 drive_low", drive_low, 1'b0);
        check("R1 drive_high", drive_high, 1'b0);
        check("R1 busy", busy, 1'b0);
        check("R1 underrun", underrun, 1'b0);
        check("R1 tx_ready", tx_ready, 1'b1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 one-cycle glitch must not start a slot
        host_low = 1'b1;
        @(negedge clk);
        host_low = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R2 glitch busy", busy, 1'b0);
            check("R2 glitch drive_low", drive_low, 1'b0);
        end

        // R3 zero with host holding long, R4 one
        load(1'b0);
        run_slot(5, 1'b0, 1'b0);
        load(1'b1);
        run_slot(2, 1'b0, 1'b0);
        // R8 underrun slot
        run_slot(3, 1'b0, 1'b0);
        // R7 load during slot, used next
        load(1'b1);
        run_slot(2, 1'b1, 1'b0);
        run_slot(4, 1'b0, 1'b0);

        for (int n = 0; n < 40; n++) begin
            int hold;
            bit mid;
            if (!model_have && ($urandom % 4 != 0)) load(1'($urandom % 2));
            hold = 2 + int'($urandom % 4);
            mid = ($urandom % 3 == 0) && !model_have;
            run_slot(hold, mid, 1'($urandom % 2));
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule